// File: doc/BRIEF.md
# Two-Channel Motor Drive Control Register Slave

This block is a write-only serial slave on a two-wire I2C bus that holds the control settings of a two-channel piezo motor driver. It oversamples the bus clock and data lines with a fast system clock. Each line is synchronized and then filtered against short glitches. The block detects bus start and stop conditions and checks the 7-bit device address. It acknowledges every accepted byte and writes the payload into a sparse register map through an auto-incrementing pointer.

A transaction is a START, the device address with the write direction bit, a register index, and then one or more data bytes. A single data byte is a plain register write. Further data bytes go to consecutive indices. The settings appear as parallel outputs. For each channel these are the switching period, an 11-bit pulse count with its direction, and a duty setting. Shared between the channels are a boost-voltage code, a spare byte and a clock-doubling enable. A pulse count takes effect only when its low byte is written, and a one-cycle load strobe marks that moment. The active-low power-down input returns all registers to their defaults.

Top module: `mdrvI2cRegs`

## Requirements
- R1: The slave acknowledges an address byte by pulling SDA low through the ninth SCL high phase. The byte must match the 7-bit address formed by the six fixed bits DEV_ADDR_HI (default 6'b011010) above the level of `addrSel`, with the direction bit (bit 0 of the byte, MSB sent first) equal to 0.
- R2: An address byte that does not match is not acknowledged. All later bytes are then ignored, with no acknowledge and no register change, until the next START.
- R3: After a matching address, both the register-index byte and every data byte are acknowledged on their ninth clock.
- R4: A transaction made of START, address, index and one data byte stores that byte at the indexed register. No register changes without a data byte.
- R5: Further data bytes in the same transaction are stored at index+1, index+2 and so on.
- R6: A data byte aimed at an unmapped index (anything other than 00h to 08h and 10h) is acknowledged and discarded, and the pointer still advances.
- R7: The pulse-count high bytes are at 01h (channel A) and 04h (channel B), and the low bytes at 02h and 05h. A low-byte write sets the applied count to {high[2:0], low} and the direction to bit 6 of the high byte, and raises that channel's load strobe for exactly one cycle. A write to a high byte alone leaves the applied count and direction unchanged.
- R8: `clkDoubleEn` is 1 only when bit 7 is set in both high bytes (01h and 04h).
- R9: While `pwrDownN` is low, the voltage code (06h) is 27h. The period (00h, 03h), duty (07h, 08h), spare (10h) and pulse-count registers are all 00h, and SDA is released.
- R10: A matching address with the direction bit set to 1 (read) is not acknowledged.
- R11: A pulse of one system-clock cycle on SCL or SDA does not shift in a bit and does not create a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| pwrDownN | input | 1 | Active-low power-down; restores the default register values |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level |
| addrSel | input | 1 | Sets the least significant bit of the device address |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| periodA | output | 8 | Channel A period divider |
| periodB | output | 8 | Channel B period divider |
| pulseCntA | output | 11 | Channel A applied pulse count |
| pulseCntB | output | 11 | Channel B applied pulse count |
| dirA | output | 1 | Channel A applied direction |
| dirB | output | 1 | Channel B applied direction |
| loadA | output | 1 | One-cycle strobe when channel A count is applied |
| loadB | output | 1 | One-cycle strobe when channel B count is applied |
| clkDoubleEn | output | 1 | Clock doubling enable (both channel flags set) |
| voltCode | output | 8 | Boost voltage code |
| dutyA | output | 8 | Channel A duty setting |
| dutyB | output | 8 | Channel B duty setting |
| spareReg | output | 8 | Reserved register at 10h |

## Verification
Directed transactions cover each single-register write, a page write that crosses the unmapped gap, a wrong address and a read request. These separate a decoder that acts on every byte from one that stops at the address. A page write begun at 01h tells a count that loads on the low byte apart from one that loads on the high byte, and the load-strobe counters show whether a strobe was dropped or repeated. Bytes sent with injected one-cycle pulses on SCL and SDA show whether the filter blocks stray bits and stray start or stop conditions. Seeded random page writes of random length and start index are compared against a bench model, followed by a power-down that must restore every default.

// File: rtl/mdrvRegPkg.sv
package mdrvRegPkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              ptrLoad;
    logic              wrEn;
    logic [BYTE_W-1:0] wrData;
  } ctlStb_t;

  localparam int          CH_STRIDE  = 3;
  localparam logic [7:0]  ADDR_VOLT  = 8'h06;
  localparam logic [7:0]  ADDR_DUTY0 = 8'h07;
  localparam logic [7:0]  ADDR_SPARE = 8'h10;
  localparam logic [7:0]  VOLT_DEF   = 8'h27;
  localparam int          HI_DBL_BIT = 7;
  localparam int          HI_DIR_BIT = 6;
endpackage

// File: rtl/busFilter.sv
module busFilter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  logic [1:0]          syncQ;
  logic [FILT_LEN-1:0] hist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      hist    <= '1;
      filtOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      hist  <= {hist[FILT_LEN-2:0], syncQ[1]};
      if (&hist)       filtOut <= 1'b1;
      else if (~|hist) filtOut <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cCtrl.sv
module i2cCtrl
  import mdrvRegPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b011010,
  parameter int         FILT_LEN    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    addrSel,
  output logic    sdaPullLow,
  output ctlStb_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_DATA, S_ACK, S_IGNORE} st_t;

  logic sclF, sdaF, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;
  st_t  state, afterAck;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shiftReg;

  busFilter #(.FILT_LEN(FILT_LEN)) u_sclFilt (.clk(clk), .rstN(rstN), .rawIn(sclIn), .filtOut(sclF));
  busFilter #(.FILT_LEN(FILT_LEN)) u_sdaFilt (.clk(clk), .rstN(rstN), .rawIn(sdaIn), .filtOut(sdaF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      afterAck   <= S_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      sdaPullLow <= 1'b0;
      stb        <= '0;
    end else begin
      stb <= '0;
      if (startDet) begin
        state      <= S_ADDR;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopDet) begin
        state      <= S_IDLE;
        sdaPullLow <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_REG, S_DATA: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaF};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (shiftReg[7:1] == {DEV_ADDR_HI, addrSel} && !shiftReg[0]) begin
                  sdaPullLow <= 1'b1;
                  state      <= S_ACK;
                  afterAck   <= S_REG;
                end else begin
                  state <= S_IGNORE;
                end
              end else begin
                stb.ptrLoad <= (state == S_REG);
                stb.wrEn    <= (state == S_DATA);
                stb.wrData  <= shiftReg;
                sdaPullLow  <= 1'b1;
                state       <= S_ACK;
                afterAck    <= S_DATA;
              end
            end
          end
          S_ACK: begin
            if (sclFall) begin
              sdaPullLow <= 1'b0;
              bitCnt     <= '0;
              state      <= afterAck;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  ack_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> (state == S_ACK));

  // R2
  ignore_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |=> !stb.wrEn && !stb.ptrLoad);
endmodule

// File: rtl/regBank.sv
module regBank
  import mdrvRegPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 11
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctlStb_t                            stb,
  output logic [NUM_CH-1:0][BYTE_W-1:0]      periodOut,
  output logic [NUM_CH-1:0][CNT_W-1:0]       cntOut,
  output logic [NUM_CH-1:0]                  dirOut,
  output logic [NUM_CH-1:0]                  loadOut,
  output logic [NUM_CH-1:0][BYTE_W-1:0]      dutyOut,
  output logic                               clkDoubleEn,
  output logic [BYTE_W-1:0]                  voltOut,
  output logic [BYTE_W-1:0]                  spareOut
);
  localparam int HI_CNT_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] ptr;
  logic [NUM_CH-1:0] dblBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (stb.ptrLoad) ptr <= stb.wrData;
    else if (stb.wrEn)    ptr <= ptr + 8'd1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [7:0] PER_ADDR  = 8'(CH_STRIDE * ch);
    localparam logic [7:0] HI_ADDR   = 8'(CH_STRIDE * ch + 1);
    localparam logic [7:0] LO_ADDR   = 8'(CH_STRIDE * ch + 2);
    localparam logic [7:0] DUTY_ADDR = 8'(ADDR_DUTY0 + 8'(ch));

    logic [HI_CNT_W-1:0] hiCnt;
    logic                hiDir;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        periodOut[ch] <= '0;
        hiCnt         <= '0;
        hiDir         <= 1'b0;
        dblBit[ch]    <= 1'b0;
        cntOut[ch]    <= '0;
        dirOut[ch]    <= 1'b0;
        loadOut[ch]   <= 1'b0;
        dutyOut[ch]   <= '0;
      end else begin
        loadOut[ch] <= 1'b0;
        if (stb.wrEn) begin
          if (ptr == PER_ADDR) periodOut[ch] <= stb.wrData;
          if (ptr == HI_ADDR) begin
            hiCnt      <= stb.wrData[HI_CNT_W-1:0];
            hiDir      <= stb.wrData[HI_DIR_BIT];
            dblBit[ch] <= stb.wrData[HI_DBL_BIT];
          end
          if (ptr == LO_ADDR) begin
            cntOut[ch]  <= {hiCnt, stb.wrData};
            dirOut[ch]  <= hiDir;
            loadOut[ch] <= 1'b1;
          end
          if (ptr == DUTY_ADDR) dutyOut[ch] <= stb.wrData;
        end
      end
    end

    // R7
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      loadOut[ch] |=> !loadOut[ch]);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntOut[ch] != $past(cntOut[ch]) || dirOut[ch] != $past(dirOut[ch])) |-> loadOut[ch]);
  end

  assign clkDoubleEn = &dblBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voltOut  <= VOLT_DEF;
      spareOut <= '0;
    end else if (stb.wrEn) begin
      if (ptr == ADDR_VOLT)  voltOut  <= stb.wrData;
      if (ptr == ADDR_SPARE) spareOut <= stb.wrData;
    end
  end

  // R4
  volt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (voltOut != $past(voltOut)) |-> $past(stb.wrEn));

  // R4
  spare_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spareOut != $past(spareOut)) |-> $past(stb.wrEn));
endmodule

// File: rtl/mdrvI2cRegs.sv
module mdrvI2cRegs
  import mdrvRegPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b011010,
  parameter int         FILT_LEN    = 3,
  parameter int         CNT_W       = 11
) (
  input  logic              clk,
  input  logic              pwrDownN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  output logic              sdaPullLow,
  output logic [7:0]        periodA,
  output logic [7:0]        periodB,
  output logic [CNT_W-1:0]  pulseCntA,
  output logic [CNT_W-1:0]  pulseCntB,
  output logic              dirA,
  output logic              dirB,
  output logic              loadA,
  output logic              loadB,
  output logic              clkDoubleEn,
  output logic [7:0]        voltCode,
  output logic [7:0]        dutyA,
  output logic [7:0]        dutyB,
  output logic [7:0]        spareReg
);
  localparam int NUM_CH = 2;

  ctlStb_t stb;
  logic [NUM_CH-1:0][BYTE_W-1:0] periodV, dutyV;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntV;
  logic [NUM_CH-1:0]             dirV, loadV;

  i2cCtrl #(.DEV_ADDR_HI(DEV_ADDR_HI), .FILT_LEN(FILT_LEN)) u_ctrl (
    .clk(clk), .rstN(pwrDownN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrSel(addrSel), .sdaPullLow(sdaPullLow), .stb(stb)
  );

  regBank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rstN(pwrDownN), .stb(stb),
    .periodOut(periodV), .cntOut(cntV), .dirOut(dirV), .loadOut(loadV),
    .dutyOut(dutyV), .clkDoubleEn(clkDoubleEn), .voltOut(voltCode),
    .spareOut(spareReg)
  );

  assign periodA   = periodV[0];
  assign periodB   = periodV[1];
  assign pulseCntA = cntV[0];
  assign pulseCntB = cntV[1];
  assign dirA      = dirV[0];
  assign dirB      = dirV[1];
  assign loadA     = loadV[0];
  assign loadB     = loadV[1];
  assign dutyA     = dutyV[0];
  assign dutyB     = dutyV[1];
endmodule

// File: tb/mdrvI2cRegs_tb.sv
module mdrvI2cRegs_tb;
  localparam logic [5:0] ADDR_HI = 6'b011010;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic pwrDownN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b1;
  logic sdaBus;
  logic sdaPullLow, dirA, dirB, loadA, loadB, clkDoubleEn;
  logic [7:0] periodA, periodB, voltCode, dutyA, dutyB, spareReg;
  logic [10:0] pulseCntA, pulseCntB;

  int total = 0, bad = 0, nLoadA = 0, nLoadB = 0;
  bit done = 0;

  logic [7:0] mPer [2], mHi [2], mDuty [2];
  logic [10:0] mCnt [2];
  logic mDir [2];
  logic [7:0] mVolt, mSpare;
  int expLoad [2];
  logic [7:0] wbuf [0:7];

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  mdrvI2cRegs u_dut (
    .clk(clk), .pwrDownN(pwrDownN), .sclIn(sclM), .sdaIn(sdaBus), .addrSel(addrSel),
    .sdaPullLow(sdaPullLow), .periodA(periodA), .periodB(periodB),
    .pulseCntA(pulseCntA), .pulseCntB(pulseCntB), .dirA(dirA), .dirB(dirB),
    .loadA(loadA), .loadB(loadB), .clkDoubleEn(clkDoubleEn), .voltCode(voltCode),
    .dutyA(dutyA), .dutyB(dutyB), .spareReg(spareReg)
  );

  always @(posedge clk) begin
    if (loadA) nLoadA++;
    if (loadB) nLoadB++;
  end

  function automatic logic [10:0] composeCnt(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[2:0], lo};
  endfunction

  function automatic logic [7:0] devByte(input logic sel, input logic rd);
    return {ADDR_HI, sel, rd};
  endfunction

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mdlReset();
    for (int c = 0; c < 2; c++) begin
      mPer[c] = 0; mHi[c] = 0; mDuty[c] = 0; mCnt[c] = 0; mDir[c] = 0;
    end
    mVolt = 8'h27; mSpare = 0;
  endtask

  task automatic mdlWr(input logic [7:0] p, input logic [7:0] d);
    case (p)
      8'h00: mPer[0] = d;
      8'h01: mHi[0] = d;
      8'h02: begin mCnt[0] = composeCnt(mHi[0], d); mDir[0] = mHi[0][6]; expLoad[0]++; end
      8'h03: mPer[1] = d;
      8'h04: mHi[1] = d;
      8'h05: begin mCnt[1] = composeCnt(mHi[1], d); mDir[1] = mHi[1][6]; expLoad[1]++; end
      8'h06: mVolt = d;
      8'h07: mDuty[0] = d;
      8'h08: mDuty[1] = d;
      8'h10: mSpare = d;
      default: ;
    endcase
  endtask

  task automatic checkRegs(input string tag);
    chk({tag, " periodA"}, periodA, mPer[0]);
    chk({tag, " periodB"}, periodB, mPer[1]);
    chk({tag, " pulseCntA"}, pulseCntA, mCnt[0]);
    chk({tag, " pulseCntB"}, pulseCntB, mCnt[1]);
    chk({tag, " dirA"}, dirA, mDir[0]);
    chk({tag, " dirB"}, dirB, mDir[1]);
    chk({tag, " clkDoubleEn R8"}, clkDoubleEn, mHi[0][7] & mHi[1][7]);
    chk({tag, " voltCode"}, voltCode, mVolt);
    chk({tag, " dutyA"}, dutyA, mDuty[0]);
    chk({tag, " dutyB"}, dutyB, mDuty[1]);
    chk({tag, " spareReg"}, spareReg, mSpare);
    chk({tag, " loadA count R7"}, nLoadA, expLoad[0]);
    chk({tag, " loadB count R7"}, nLoadB, expLoad[1]);
  endtask

  task automatic i2cStart();
    sdaM = 1; waitC(Q); sclM = 1; waitC(Q); sdaM = 0; waitC(Q); sclM = 0; waitC(Q);
  endtask

  task automatic i2cStop();
    sdaM = 0; waitC(Q); sclM = 1; waitC(Q); sdaM = 1; waitC(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (glitch) begin
        waitC(3); sclM = 1; waitC(1); sclM = 0; waitC(Q - 4);
      end else waitC(Q);
      sclM = 1;
      if (glitch) begin
        waitC(4); sdaM = ~sdaM; waitC(1); sdaM = ~sdaM; waitC(2 * Q - 5);
      end else waitC(2 * Q);
      sclM = 0; waitC(Q);
    end
    sdaM = 1; waitC(Q); sclM = 1; waitC(Q);
    acked = (sdaBus == 1'b0);
    waitC(Q); sclM = 0; waitC(Q);
  endtask

  task automatic pageWrite(input string tag, input logic [7:0] idx, input int n, input bit glitch);
    bit ack;
    int nack = 0;
    i2cStart();
    sendByte(devByte(1'b1, 1'b0), glitch, ack); if (!ack) nack++;
    sendByte(idx, glitch, ack); if (!ack) nack++;
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], glitch, ack); if (!ack) nack++;
      mdlWr(8'(idx + 8'(k)), wbuf[k]);
    end
    i2cStop();
    chk({tag, " acks R1 R3"}, nack, 0);
    checkRegs(tag);
  endtask

  initial begin
    bit ack;
    int unsigned r;
    r = $urandom(32'h5EED1234);
    mdlReset();
    expLoad[0] = 0; expLoad[1] = 0;
    waitC(5);
    checkRegs("R9 reset");
    chk("R9 sda released", sdaPullLow, 0);
    pwrDownN = 1; waitC(10);

    // R4 single writes to each mapped register
    wbuf[0] = 8'h6F; pageWrite("R4 periodA", 8'h00, 1, 0);
    wbuf[0] = 8'h8E; pageWrite("R4 periodB", 8'h03, 1, 0);
    wbuf[0] = 8'h31; pageWrite("R4 volt", 8'h06, 1, 0);
    wbuf[0] = 8'h0D; pageWrite("R4 dutyB", 8'h08, 1, 0);
    wbuf[0] = 8'hA5; pageWrite("R4 spare", 8'h10, 1, 0);
    // R4 index only, no data
    pageWrite("R4 index only", 8'h06, 0, 0);

    // R7 high byte alone keeps count; low byte loads
    wbuf[0] = 8'hC5; pageWrite("R7 hiA only", 8'h01, 1, 0);
    wbuf[0] = 8'h3C; pageWrite("R7 loA", 8'h02, 1, 0);
    // R5 page write across channel B plus shared registers
    wbuf[0] = 8'h86; wbuf[1] = 8'h07; wbuf[2] = 8'hFF; wbuf[3] = 8'h11; wbuf[4] = 8'h42;
    pageWrite("R5 page B", 8'h03, 5, 0);
    // R8 one flag cleared
    wbuf[0] = 8'h04; wbuf[1] = 8'h01; pageWrite("R8 clear hiB", 8'h04, 2, 0);
    // R6 run through unmapped gap into 10h
    for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h50 + k);
    pageWrite("R6 unmapped", 8'h09, 8, 0);

    // R2 wrong address
    i2cStart();
    sendByte(devByte(1'b0, 1'b0), 0, ack); chk("R2 addr nack", ack, 0);
    sendByte(8'h06, 0, ack); chk("R2 idx ignored", ack, 0);
    sendByte(8'hEE, 0, ack); chk("R2 data ignored", ack, 0);
    i2cStop();
    checkRegs("R2 regs kept");

    // R10 read request
    i2cStart();
    sendByte(devByte(1'b1, 1'b1), 0, ack); chk("R10 read nack", ack, 0);
    sendByte(8'h07, 0, ack); chk("R10 following ignored", ack, 0);
    i2cStop();
    checkRegs("R10 regs kept");

    // R11 glitches on both lines during a page write
    wbuf[0] = 8'h99; wbuf[1] = 8'h5A; pageWrite("R11 glitch", 8'h07, 2, 1);

    // R5 random page writes
    for (int t = 0; t < 30; t++) begin
      int n;
      logic [7:0] idx;
      idx = 8'($urandom_range(0, 9));
      if (idx == 8'h09) idx = 8'h10;
      n = $urandom_range(1, 5);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      pageWrite($sformatf("R5 random %0d", t), idx, n, 0);
    end

    // R9 power-down restores defaults
    pwrDownN = 0; waitC(3);
    mdlReset();
    checkRegs("R9 power-down");
    pwrDownN = 1; waitC(10);
    wbuf[0] = 8'h12; pageWrite("R9 after wake", 8'h00, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule